// File: doc/BRIEF.md
# Timer Counter With Shared Prescaler

This block is an 8-bit timer/counter paired with a watchdog counter, and both share one binary prescaler. The timer counts one of two sources. The first is a one-cycle instruction strobe that the clock logic supplies once per instruction cycle, which is the oscillator divided by four. The second is a chosen edge, rising or falling, on an external count pin. The count pin is brought into the clock domain through a synchronizer chain before its edges are detected. Software can read the timer and can load it at any time. When the timer wraps from 0xFF to 0x00 it sets a sticky overflow flag, which feeds the interrupt logic.

One 3-bit ratio field and one owner bit control the prescaler. When the timer owns it, the timer advances once per 2^(ratio+1) source events and the watchdog takes every tick of its own oscillator. When the watchdog owns it, the watchdog advances once per 2^ratio ticks and the timer takes every source event. The watchdog counter is free-running. When enabled, it raises a one-cycle reset request as it wraps past all ones. A clear strobe restarts the watchdog counter. If the watchdog owns the prescaler, the same strobe also restarts the prescaler count.

Top module: `tmr_psc_unit`

## Requirements
- R1: After reset the timer reads 0, the overflow flag is 0, the watchdog reset request is 0, and the prescaler and watchdog counts are 0.
- R2: With the internal source (`cfg_src_ext`=0) and the prescaler owned by the timer (`cfg_psc_wdt`=0), the timer advances by 1 once per 2^(`cfg_ratio`+1) instruction strobes.
- R3: With `cfg_src_ext`=1 the count pin passes through two flip-flops and an edge detector. `cfg_edge_fall`=0 counts rising edges and `cfg_edge_fall`=1 counts falling edges; the other edge is ignored. A counted edge shows in the timer value three clock edges after the pin changes.
- R4: With `cfg_psc_wdt`=1 the timer advances by 1 on every source event, whatever the value of `cfg_ratio`.
- R5: A write (`tmr_wr`=1) loads `tmr_wdata` on the next edge and takes precedence over a count in the same cycle. When the timer owns the prescaler, the write also clears the prescaler count.
- R6: A count taken while the timer holds 0xFF wraps it to 0x00 and sets `tmr_ovf_flag`. The flag stays set until `tmr_flag_clr` is pulsed, and a set in the same cycle wins over the clear.
- R7: With `cfg_psc_wdt`=1 the watchdog advances once per 2^`cfg_ratio` ticks of `wdt_tick`. With `cfg_psc_wdt`=0 it advances on every tick.
- R8: The watchdog counter is 8 bits wide. When it advances from 0xFF it wraps to 0 and `wdt_reset_req` goes high for exactly one cycle. While `wdt_en`=0 the counter is held at 0 and no request is raised.
- R9: `wdt_clr` zeroes the watchdog counter. When the watchdog owns the prescaler, it also zeroes the prescaler count.
- R10: The timer holds its value in any cycle that has neither a count nor a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icyc_en | input | 1 | Instruction-cycle strobe (internal count source) |
| cfg_src_ext | input | 1 | 1: count the external pin, 0: count instruction strobes |
| cfg_edge_fall | input | 1 | 1: falling edges of the pin, 0: rising edges |
| cfg_psc_wdt | input | 1 | 1: prescaler owned by the watchdog, 0: by the timer |
| cfg_ratio | input | 3 | Prescaler ratio select |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_rdata | output | 8 | Current timer value |
| tmr_flag_clr | input | 1 | Clears the overflow flag |
| tmr_ovf_flag | output | 1 | Sticky timer overflow flag |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| wdt_tick | input | 1 | One-cycle pulse from the watchdog oscillator |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_reset_req | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The assertions check the cycle-level rules on every cycle. A write loads on the next edge, the timer either holds or advances by exactly one, the overflow flag is sticky and sets on a wrap, clears zero their counters, a disabled watchdog stays at zero, and the edge detector never reports two counts in a row. Other behaviour can only be shown by the bench's scenarios, because it depends on long sequences of input events. These are the division ratio chosen by the owner bit and ratio field, the three-edge latency from the pin, the rejection of the edge that is not selected, and the exact tick count at which the watchdog times out with and without a prescaler clear.

// File: rtl/tmr_psc_pkg.sv
package tmr_psc_pkg;

   // Which counter the prescaler currently serves
   typedef enum logic {
      PSC_TO_TMR = 1'b0,
      PSC_TO_WDT = 1'b1
   } psc_owner_e;

   // Edge of the external count pin that is counted
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } pin_edge_e;

   // Number of prescaler stages for a given ratio field and owner
   function automatic int unsigned psc_shift(input int unsigned ratio,
                                             input psc_owner_e owner);
      return (owner == PSC_TO_TMR) ? ratio + 1 : ratio;
   endfunction

endpackage

// File: rtl/tmr_psc_edge.sv
module tmr_psc_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   input  logic edge_fall,
   output logic evt
);
   import tmr_psc_pkg::*;

   initial begin
      assert (SYNC_STAGES >= 2)
         else $error("tmr_psc_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pin_s;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= pin_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   always_comb begin
      if (pin_edge_e'(edge_fall) == EDGE_FALL) evt = prev_q & ~pin_s;
      else                                     evt = pin_s & ~prev_q;
   end

   // R3: one edge of the chosen kind cannot be reported on two consecutive cycles
   a_r3_single_evt: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && $stable(edge_fall)) |=> !evt);

endmodule

// File: rtl/tmr_psc_div.sv
module tmr_psc_div #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_evt,
   input  logic               clr,
   input  logic               owner_wdt,
   input  logic [RATIO_W-1:0] ratio,
   output logic               out_evt
);
   import tmr_psc_pkg::*;

   localparam int PSC_W   = 2 ** RATIO_W;
   localparam int SHIFT_W = RATIO_W + 1;

   initial begin
      assert (RATIO_W >= 1 && RATIO_W <= 4)
         else $error("tmr_psc_div: RATIO_W out of range");
   end

   logic [PSC_W-1:0]   cnt_q;
   logic [PSC_W-1:0]   mask;
   logic [SHIFT_W-1:0] shift;

   assign shift = SHIFT_W'(psc_shift(int'(ratio), psc_owner_e'(owner_wdt)));

   // Low 'shift' bits of the count must all be one for an output event
   always_comb begin
      for (int i = 0; i < PSC_W; i++) begin
         mask[i] = (i < int'(shift));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (in_evt) cnt_q <= cnt_q + PSC_W'(1);
   end

   assign out_evt = in_evt && !clr && ((cnt_q & mask) == mask);

   // R5 / R9: a clear leaves the count at zero
   a_r9_psc_clr: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // R10: count holds without input event or clear
   a_r10_psc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !in_evt) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_psc_core.sv
module tmr_psc_core #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wr,
   input  logic [TMR_W-1:0] wdata,
   input  logic             flag_clr,
   output logic [TMR_W-1:0] cnt,
   output logic             ovf_flag
);
   initial begin
      assert (TMR_W >= 2)
         else $error("tmr_psc_core: TMR_W must be at least 2");
   end

   logic [TMR_W-1:0] cnt_q;
   logic             flag_q;
   logic             wrap;

   assign wrap = step && !wr && (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (wr)   cnt_q <= wdata;
      else if (step) cnt_q <= cnt_q + TMR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (wrap)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign cnt      = cnt_q;
   assign ovf_flag = flag_q;

   // R5: write loads the data
   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cnt == $past(wdata)));

   // R2: a count advances by exactly one
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr) |=> (cnt == $past(cnt) + TMR_W'(1)));

   // R10: no count, no write, no change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !wr) |=> $stable(cnt));

   // R6: wrap sets the flag, flag is sticky until cleared
   a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && cnt == '1) |=> (ovf_flag && cnt == '0));
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr) |=> ovf_flag);

endmodule

// File: rtl/tmr_psc_wdog.sv
module tmr_psc_wdog #(
   parameter int WDT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic step,
   input  logic clr,
   output logic timeout
);
   initial begin
      assert (WDT_W >= 2)
         else $error("tmr_psc_wdog: WDT_W must be at least 2");
   end

   logic [WDT_W-1:0] cnt_q;
   logic             to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else if (!en || clr) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else begin
         to_q <= step && (cnt_q == '1);
         if (step) cnt_q <= cnt_q + WDT_W'(1);
      end
   end

   assign timeout = to_q;

   // R8: disabled watchdog stays at zero and quiet
   a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0 && !timeout));

   // R8: a timeout is a single-cycle pulse
   a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   // R8: timeout only follows a step from all ones
   a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> ($past(step) && cnt_q == '0));

   // R9: clear zeroes the counter
   a_r9_clr: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_psc_unit.sv
module tmr_psc_unit #(
   parameter int TMR_W       = 8,
   parameter int RATIO_W     = 3,
   parameter int WDT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               icyc_en,
   input  logic               cfg_src_ext,
   input  logic               cfg_edge_fall,
   input  logic               cfg_psc_wdt,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic               tmr_wr,
   input  logic [TMR_W-1:0]   tmr_wdata,
   output logic [TMR_W-1:0]   tmr_rdata,
   input  logic               tmr_flag_clr,
   output logic               tmr_ovf_flag,
   input  logic               cnt_pin,
   input  logic               wdt_tick,
   input  logic               wdt_en,
   input  logic               wdt_clr,
   output logic               wdt_reset_req
);
   import tmr_psc_pkg::*;

   psc_owner_e owner;
   logic       ext_evt;
   logic       src_evt;
   logic       psc_in;
   logic       psc_clr;
   logic       psc_out;
   logic       tmr_step;
   logic       wdt_step;

   assign owner = psc_owner_e'(cfg_psc_wdt);

   tmr_psc_edge #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (cnt_pin),
      .edge_fall (cfg_edge_fall),
      .evt       (ext_evt)
   );

   assign src_evt = cfg_src_ext ? ext_evt : icyc_en;

   // Route the shared prescaler to its current owner
   always_comb begin
      if (owner == PSC_TO_WDT) begin
         psc_in   = wdt_tick;
         psc_clr  = wdt_clr;
         tmr_step = src_evt;
         wdt_step = psc_out;
      end else begin
         psc_in   = src_evt;
         psc_clr  = tmr_wr;
         tmr_step = psc_out;
         wdt_step = wdt_tick;
      end
   end

   tmr_psc_div #(
      .RATIO_W(RATIO_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_evt    (psc_in),
      .clr       (psc_clr),
      .owner_wdt (cfg_psc_wdt),
      .ratio     (cfg_ratio),
      .out_evt   (psc_out)
   );

   tmr_psc_core #(
      .TMR_W(TMR_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (tmr_step),
      .wr       (tmr_wr),
      .wdata    (tmr_wdata),
      .flag_clr (tmr_flag_clr),
      .cnt      (tmr_rdata),
      .ovf_flag (tmr_ovf_flag)
   );

   tmr_psc_wdog #(
      .WDT_W(WDT_W)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wdt_en),
      .step    (wdt_step),
      .clr     (wdt_clr),
      .timeout (wdt_reset_req)
   );

   // R4: with the prescaler elsewhere every source event reaches the timer
   a_r4_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_psc_wdt && src_evt && !tmr_wr) |=> (tmr_rdata == $past(tmr_rdata) + TMR_W'(1)));

   // R7: with the prescaler elsewhere the watchdog is never stepped without a tick
   a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdt_tick) |-> !wdt_step);

endmodule

// File: tb/sim_tmr_psc_unit.sv
`timescale 1ns/1ps
module sim_tmr_psc_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       icyc_en = 1'b0;
   logic       cfg_src_ext = 1'b0;
   logic       cfg_edge_fall = 1'b0;
   logic       cfg_psc_wdt = 1'b0;
   logic [2:0] cfg_ratio = 3'd0;
   logic       tmr_wr = 1'b0;
   logic [7:0] tmr_wdata = 8'd0;
   logic [7:0] tmr_rdata;
   logic       tmr_flag_clr = 1'b0;
   logic       tmr_ovf_flag;
   logic       cnt_pin = 1'b0;
   logic       wdt_tick = 1'b0;
   logic       wdt_en = 1'b0;
   logic       wdt_clr = 1'b0;
   logic       wdt_reset_req;

   int n_cmp = 0;
   int n_bad = 0;
   int n_to  = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   tmr_psc_unit u0 (
      .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en),
      .cfg_src_ext(cfg_src_ext), .cfg_edge_fall(cfg_edge_fall),
      .cfg_psc_wdt(cfg_psc_wdt), .cfg_ratio(cfg_ratio),
      .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
      .tmr_flag_clr(tmr_flag_clr), .tmr_ovf_flag(tmr_ovf_flag),
      .cnt_pin(cnt_pin), .wdt_tick(wdt_tick), .wdt_en(wdt_en),
      .wdt_clr(wdt_clr), .wdt_reset_req(wdt_reset_req)
   );

   always @(negedge clk) if (rst_n && wdt_reset_req) n_to++;

   // {ratio, owner_wdt, strobes, expected timer}
   localparam logic [31:0] VEC [7] = '{
      {4'd0, 4'd0, 16'd7,   8'd3},
      {4'd1, 4'd0, 16'd9,   8'd2},
      {4'd2, 4'd0, 16'd16,  8'd2},
      {4'd3, 4'd0, 16'd47,  8'd2},
      {4'd7, 4'd0, 16'd300, 8'd1},
      {4'd5, 4'd1, 16'd5,   8'd5},
      {4'd0, 4'd1, 16'd9,   8'd9}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) icyc_en = 1'b1;
         @(negedge clk) icyc_en = 1'b0;
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) wdt_tick = 1'b1;
         @(negedge clk) wdt_tick = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic twrite(input logic [7:0] d);
      @(negedge clk) begin tmr_wr = 1'b1; tmr_wdata = d; end
      @(negedge clk) tmr_wr = 1'b0;
   endtask

   task automatic wclear();
      @(negedge clk) wdt_clr = 1'b1;
      @(negedge clk) wdt_clr = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 timer", tmr_rdata, 0);
      chk("R1 flag", tmr_ovf_flag, 0);
      chk("R1 wdt req", wdt_reset_req, 0);
      rst_n = 1'b1;
      wait_n(2);

      // R2 / R4: ratio table
      for (int v = 0; v < 7; v++) begin
         @(negedge clk) begin
            cfg_ratio   = VEC[v][30:28];
            cfg_psc_wdt = VEC[v][24];
         end
         twrite(8'h00);
         strobe(int'(VEC[v][23:8]));
         chk(VEC[v][24] ? "R4 direct count" : "R2 prescaled count",
             tmr_rdata, int'(VEC[v][7:0]));
      end

      // R3: external rising edges, three-edge latency
      @(negedge clk) begin cfg_src_ext = 1'b1; cfg_edge_fall = 1'b0; cfg_psc_wdt = 1'b1; end
      twrite(8'h00);
      @(negedge clk) cnt_pin = 1'b1;
      wait_n(2);
      chk("R3 latency not yet", tmr_rdata, 0);
      wait_n(1);
      chk("R3 rising counted", tmr_rdata, 1);
      @(negedge clk) cnt_pin = 1'b0;
      wait_n(4);
      chk("R3 falling ignored", tmr_rdata, 1);
      @(negedge clk) cfg_edge_fall = 1'b1;
      @(negedge clk) cnt_pin = 1'b1;
      wait_n(4);
      chk("R3 rising ignored", tmr_rdata, 1);
      @(negedge clk) cnt_pin = 1'b0;
      wait_n(3);
      chk("R3 falling counted", tmr_rdata, 2);
      @(negedge clk) begin cfg_src_ext = 1'b0; cfg_edge_fall = 1'b0; end

      // R5: write beats a same-cycle count
      @(negedge clk) begin icyc_en = 1'b1; tmr_wr = 1'b1; tmr_wdata = 8'h40; end
      @(negedge clk) begin icyc_en = 1'b0; tmr_wr = 1'b0; end
      chk("R5 write priority", tmr_rdata, 8'h40);

      // R5: write clears the timer-owned prescaler
      @(negedge clk) begin cfg_psc_wdt = 1'b0; cfg_ratio = 3'd1; end
      twrite(8'h00);
      strobe(3);
      twrite(8'h10);
      strobe(3);
      chk("R5 prescaler cleared", tmr_rdata, 8'h10);
      strobe(1);
      chk("R5 count after clear", tmr_rdata, 8'h11);

      // R10: hold without events
      wait_n(5);
      chk("R10 hold", tmr_rdata, 8'h11);

      // R6: wrap and sticky flag
      @(negedge clk) cfg_psc_wdt = 1'b1;
      twrite(8'hFE);
      strobe(1);
      chk("R6 at FF", tmr_rdata, 8'hFF);
      chk("R6 no flag yet", tmr_ovf_flag, 0);
      strobe(1);
      chk("R6 wrapped", tmr_rdata, 0);
      chk("R6 flag set", tmr_ovf_flag, 1);
      strobe(2);
      chk("R6 flag sticky", tmr_ovf_flag, 1);
      @(negedge clk) tmr_flag_clr = 1'b1;
      @(negedge clk) tmr_flag_clr = 1'b0;
      chk("R6 flag cleared", tmr_ovf_flag, 0);
      twrite(8'hFF);
      @(negedge clk) begin icyc_en = 1'b1; tmr_flag_clr = 1'b1; end
      @(negedge clk) begin icyc_en = 1'b0; tmr_flag_clr = 1'b0; end
      chk("R6 set beats clear", tmr_ovf_flag, 1);

      // R8: disabled watchdog never times out
      @(negedge clk) begin cfg_psc_wdt = 1'b0; wdt_en = 1'b0; end
      n_to = 0;
      ticks(600);
      chk("R8 disabled", n_to, 0);

      // R7 / R8: prescaler with timer, every tick steps the watchdog
      @(negedge clk) wdt_en = 1'b1;
      wclear();
      n_to = 0;
      ticks(255);
      chk("R8 no timeout at 255", n_to, 0);
      ticks(1);
      chk("R8 timeout at 256", n_to, 1);
      chk("R8 single pulse", wdt_reset_req, 0);

      // R7: watchdog owns prescaler, ratio 2 divides by 4
      @(negedge clk) begin cfg_psc_wdt = 1'b1; cfg_ratio = 3'd2; end
      wclear();
      n_to = 0;
      ticks(1023);
      chk("R7 no timeout at 1023", n_to, 0);
      ticks(1);
      chk("R7 timeout at 1024", n_to, 1);

      // R9: clear restarts counter and watchdog-owned prescaler
      wclear();
      n_to = 0;
      ticks(2);
      wclear();
      ticks(1023);
      chk("R9 prescaler cleared", n_to, 0);
      ticks(1);
      chk("R9 timeout after clear", n_to, 1);
      @(negedge clk) cfg_ratio = 3'd0;
      wclear();
      n_to = 0;
      ticks(200);
      wclear();
      ticks(200);
      chk("R9 counter cleared", n_to, 0);
      ticks(56);
      chk("R9 timeout at 256 after clear", n_to, 1);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule